// File: doc/BRIEF.md
# Receive/Transmit Slot Phase Sequencer

This block is the control core of a short-range radio front end. It turns one burst-enable line, one timing line and a few configuration bits into the internal control states of a single radio slot. A host loads a configuration word, which raises a one-cycle strobe, and then pulses the enable line. While enable is high the synthesizer loop is closed so it can settle. The falling edge of enable opens the loop for open-loop modulation or demodulation, unless the configuration asks for the loop to stay closed for the whole slot.

The timing line means different things in each direction. In receive, it walks the slicer-level estimator through three phases. The first is a fast min/max estimate, the second is integrator refinement, and the third holds the value with slow drift tracking. A configuration bit chooses which filter the refinement phase uses. In transmit, the same line switches on the output amplifier. A ramp-up bit decides whether the antenna switch moves to transmit when enable falls, or at the same moment as the amplifier. If enable is pulsed with no new configuration loaded since the last slot, that pulse ends the slot and returns every output to idle.

All inputs are synchronous to `clk`. Edges are found by comparing each input with its value on the previous clock. Every output is registered, or decoded straight from registered state.

Top module: `slot_seq`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, every output is 0. A phase code of 0 means off and a filter code of 0 means none.
- R2: A rising edge of `slotEn` counts as a slot start if `cfgStrobe` has pulsed since the previous rising edge, or pulses in the same cycle. A slot start sets `pllClosed` to 1 and clears all other enables. It also sets `preAmpEn` to 1 when `cfgRx` is 0 (transmit).
- R3: On the falling edge of `slotEn` in a started slot, `pllClosed` takes the value of the `cfgPllHold` bit that was captured at slot start, so 0 opens the loop.
- R4: In receive (`cfgRx` = 1), that falling edge sets `rxChainEn` to 1, `dcPhase` to 1 (coarse) and `dcFilt` to 1 (min/max).
- R5: In receive, a rising edge of `timeLine` while the phase is coarse moves `dcPhase` to 2 (refine). `dcFilt` then becomes 2 (medium) if `cfgDcMode` was 0, or 3 (slow) if it was 1.
- R6: In receive, a falling edge of `timeLine` while refining moves `dcPhase` to 3 (hold), with `dcFilt` at 3. Later edges of `timeLine` leave the hold phase unchanged.
- R7: In transmit with ramp mode 0 (`cfgRampMode` = 0), a rising edge of `timeLine` sets `ampEn`, whether or not `slotEn` is still high. `txSwitch` is set on the falling edge of `slotEn` instead.
- R8: In transmit with ramp mode 1, the falling edge of `slotEn` leaves `txSwitch` at 0. A rising edge of `timeLine` sets `ampEn` and `txSwitch` in the same cycle.
- R9: In transmit, a falling edge of `timeLine` has no effect, so `ampEn` stays 1.
- R10: A rising edge of `slotEn` with no `cfgStrobe` since the previous one clears every output to its reset value. The falling edge that follows it changes nothing.
- R11: The configuration bits are captured at slot start. Changing them during a slot has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgStrobe | input | 1 | One-cycle pulse: a new configuration word was loaded |
| cfgRx | input | 1 | 1 = receive slot, 0 = transmit slot |
| cfgPllHold | input | 1 | 1 = keep the synthesizer loop closed for the whole slot |
| cfgDcMode | input | 1 | Refinement filter: 0 = medium then slow, 1 = slow only |
| cfgRampMode | input | 1 | Transmit ramp ordering: 0 = switch on enable fall, 1 = switch with amplifier |
| slotEn | input | 1 | Burst enable line |
| timeLine | input | 1 | Phase and amplifier timing line |
| pllClosed | output | 1 | Synthesizer loop closed |
| rxChainEn | output | 1 | Receive chain enabled |
| dcPhase | output | 2 | Estimator phase: 0 off, 1 coarse, 2 refine, 3 hold |
| dcFilt | output | 2 | Estimator filter: 0 none, 1 min/max, 2 medium RC, 3 slow RC |
| preAmpEn | output | 1 | Transmit pre-amplifier on |
| ampEn | output | 1 | Transmit output amplifier on |
| txSwitch | output | 1 | Antenna switch in the transmit position |

## Verification
Every result is due one clock after its stimulus. A changed level on `slotEn` or `timeLine` is seen as an edge at the first rising clock that samples it, and the output registers update on that same clock. `dcFilt` is decoded from registered state and adds no delay. The bench changes inputs only at falling clock edges, lets exactly one rising edge pass, and samples at the next falling edge. Each check therefore looks at the cycle where the response must first appear. Checks for inputs that must be ignored sample at the same point, after the ignored edge and before any other stimulus.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  localparam int PHASE_W = 2;
  localparam int FILT_W  = 2;

  typedef enum logic [PHASE_W-1:0] {
    DC_OFF    = 2'd0,
    DC_COARSE = 2'd1,
    DC_FINE   = 2'd2,
    DC_HOLD   = 2'd3
  } dcPhase_e;

  typedef enum logic [FILT_W-1:0] {
    FILT_NONE   = 2'd0,
    FILT_MINMAX = 2'd1,
    FILT_MEDIUM = 2'd2,
    FILT_SLOW   = 2'd3
  } dcFilt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_OPEN  = 2'd2
  } slotState_e;

  typedef struct packed {
    logic startSlot;
    logic killSlot;
    logic openLoop;
    logic lineRise;
    logic lineFall;
  } strobes_t;

endpackage

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgStrobe,
  input  logic     slotEn,
  input  logic     timeLine,
  output strobes_t strb
);

  logic       enPrev;
  logic       linePrev;
  logic       cfgPending;
  slotState_e state;

  logic enRise, enFall, lnRise, lnFall, fresh;

  always_comb begin
    enRise = slotEn & ~enPrev;
    enFall = ~slotEn & enPrev;
    lnRise = timeLine & ~linePrev;
    lnFall = ~timeLine & linePrev;
    fresh  = cfgPending | cfgStrobe;

    strb.startSlot = enRise & fresh;
    strb.killSlot  = enRise & ~fresh;
    strb.openLoop  = enFall & (state == ST_ARMED);
    strb.lineRise  = lnRise & ~enRise & (state != ST_IDLE);
    strb.lineFall  = lnFall & ~enRise & (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev     <= 1'b0;
      linePrev   <= 1'b0;
      cfgPending <= 1'b0;
      state      <= ST_IDLE;
    end else begin
      enPrev   <= slotEn;
      linePrev <= timeLine;
      if (enRise)         cfgPending <= 1'b0;
      else if (cfgStrobe) cfgPending <= 1'b1;
      if (strb.startSlot)      state <= ST_ARMED;
      else if (strb.killSlot)  state <= ST_IDLE;
      else if (strb.openLoop)  state <= ST_OPEN;
    end
  end

  AST_OPEN_AFTER_ARM: assert property (@(posedge clk) disable iff (!rstN)
    strb.openLoop |=> (state == ST_OPEN)) else $error("loop opened outside a slot"); // R3

endmodule

// File: rtl/slot_seq_dp.sv
module slot_seq_dp
  import slot_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strb,
  input  logic     cfgRx,
  input  logic     cfgPllHold,
  input  logic     cfgDcMode,
  input  logic     cfgRampMode,
  output logic     pllClosed,
  output logic     rxChainEn,
  output dcPhase_e phase,
  output dcFilt_e  filt,
  output logic     preAmpEn,
  output logic     ampEn,
  output logic     txSwitch
);

  logic selRx, selHold, selDc, selRamp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selRx <= 1'b0; selHold <= 1'b0; selDc <= 1'b0; selRamp <= 1'b0;
      pllClosed <= 1'b0; rxChainEn <= 1'b0; phase <= DC_OFF;
      preAmpEn <= 1'b0; ampEn <= 1'b0; txSwitch <= 1'b0;
    end else if (strb.killSlot) begin
      selRx <= 1'b0; selHold <= 1'b0; selDc <= 1'b0; selRamp <= 1'b0;
      pllClosed <= 1'b0; rxChainEn <= 1'b0; phase <= DC_OFF;
      preAmpEn <= 1'b0; ampEn <= 1'b0; txSwitch <= 1'b0;
    end else if (strb.startSlot) begin
      selRx <= cfgRx; selHold <= cfgPllHold; selDc <= cfgDcMode; selRamp <= cfgRampMode;
      pllClosed <= 1'b1; rxChainEn <= 1'b0; phase <= DC_OFF;
      preAmpEn <= ~cfgRx; ampEn <= 1'b0; txSwitch <= 1'b0;
    end else begin
      if (strb.openLoop) begin
        pllClosed <= selHold;
        if (selRx) begin
          rxChainEn <= 1'b1;
          phase     <= DC_COARSE;
        end else if (!selRamp) begin
          txSwitch <= 1'b1;
        end
      end
      if (strb.lineRise) begin
        if (selRx) begin
          if (phase == DC_COARSE) phase <= DC_FINE;
        end else begin
          ampEn <= 1'b1;
          if (selRamp) txSwitch <= 1'b1;
        end
      end
      if (strb.lineFall && selRx && phase == DC_FINE) phase <= DC_HOLD;
    end
  end

  always_comb begin
    case (phase)
      DC_OFF:    filt = FILT_NONE;
      DC_COARSE: filt = FILT_MINMAX;
      DC_FINE:   filt = selDc ? FILT_SLOW : FILT_MEDIUM;
      default:   filt = FILT_SLOW;
    endcase
  end

  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == DC_HOLD) |=> (phase == DC_HOLD || phase == DC_OFF)) else $error("hold left"); // R6
  AST_FINE_FROM_COARSE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == DC_FINE && $past(phase) != DC_FINE) |-> ($past(phase) == DC_COARSE)) else $error("bad refine entry"); // R5
  AST_RX_LOOP_STATE: assert property (@(posedge clk) disable iff (!rstN)
    rxChainEn |-> (pllClosed == selHold)) else $error("loop state wrong in receive"); // R3
  AST_AMP_TX_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ampEn |-> (preAmpEn && !rxChainEn)) else $error("amplifier outside transmit"); // R7
  AST_RAMP1_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (!selRx && selRamp) |-> (ampEn == txSwitch)) else $error("ramp mode 1 split"); // R8
  AST_AMP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ampEn && !strb.killSlot && !strb.startSlot) |=> ampEn) else $error("amplifier dropped"); // R9
  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.killSlot |=> (!pllClosed && !rxChainEn && !preAmpEn && !ampEn && !txSwitch && phase == DC_OFF))
    else $error("slot end not idle"); // R10

endmodule

// File: rtl/slot_seq.sv
module slot_seq
  import slot_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStrobe,
  input  logic              cfgRx,
  input  logic              cfgPllHold,
  input  logic              cfgDcMode,
  input  logic              cfgRampMode,
  input  logic              slotEn,
  input  logic              timeLine,
  output logic              pllClosed,
  output logic              rxChainEn,
  output logic [PHASE_W-1:0] dcPhase,
  output logic [FILT_W-1:0]  dcFilt,
  output logic              preAmpEn,
  output logic              ampEn,
  output logic              txSwitch
);

  strobes_t strb;
  dcPhase_e phaseQ;
  dcFilt_e  filtQ;

  slot_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgStrobe (cfgStrobe),
    .slotEn    (slotEn),
    .timeLine  (timeLine),
    .strb      (strb)
  );

  slot_seq_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgRx       (cfgRx),
    .cfgPllHold  (cfgPllHold),
    .cfgDcMode   (cfgDcMode),
    .cfgRampMode (cfgRampMode),
    .pllClosed   (pllClosed),
    .rxChainEn   (rxChainEn),
    .phase       (phaseQ),
    .filt        (filtQ),
    .preAmpEn    (preAmpEn),
    .ampEn       (ampEn),
    .txSwitch    (txSwitch)
  );

  assign dcPhase = phaseQ;
  assign dcFilt  = filtQ;

  AST_RX_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rxChainEn && (preAmpEn || txSwitch))) else $error("receive and transmit both on"); // R4

endmodule

// File: tb/slot_seq_bench.sv
module slot_seq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgStrobe = 1'b0, cfgRx = 1'b0, cfgPllHold = 1'b0, cfgDcMode = 1'b0, cfgRampMode = 1'b0;
  logic slotEn = 1'b0, timeLine = 1'b0;
  logic pllClosed, rxChainEn, preAmpEn, ampEn, txSwitch;
  logic [1:0] dcPhase, dcFilt;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slot_seq u_slot_seq (
    .clk(clk), .rstN(rstN), .cfgStrobe(cfgStrobe), .cfgRx(cfgRx), .cfgPllHold(cfgPllHold),
    .cfgDcMode(cfgDcMode), .cfgRampMode(cfgRampMode), .slotEn(slotEn), .timeLine(timeLine),
    .pllClosed(pllClosed), .rxChainEn(rxChainEn), .dcPhase(dcPhase), .dcFilt(dcFilt),
    .preAmpEn(preAmpEn), .ampEn(ampEn), .txSwitch(txSwitch)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(req, "pllClosed", pllClosed, 0);
    chk(req, "rxChainEn", rxChainEn, 0);
    chk(req, "dcPhase", dcPhase, 0);
    chk(req, "dcFilt", dcFilt, 0);
    chk(req, "preAmpEn", preAmpEn, 0);
    chk(req, "ampEn", ampEn, 0);
    chk(req, "txSwitch", txSwitch, 0);
  endtask

  task automatic loadCfg(input logic rx, input logic hold, input logic dc, input logic ramp);
    cfgRx = rx; cfgPllHold = hold; cfgDcMode = dc; cfgRampMode = ramp;
    cfgStrobe = 1'b1;
    step();
    cfgStrobe = 1'b0;
  endtask

  task automatic endPulse();
    slotEn = 1'b1; step();
    chkIdle("R10");
    slotEn = 1'b0; step();
    chkIdle("R10");
  endtask

  task automatic testReset();
    chkIdle("R1");
    rstN = 1'b1;
    step(); step();
    chkIdle("R1");
  endtask

  task automatic testRxMode0();
    loadCfg(1'b1, 1'b0, 1'b0, 1'b0);
    slotEn = 1'b1; step();
    chk("R2", "pllClosed", pllClosed, 1);
    chk("R2", "preAmpEn", preAmpEn, 0);
    slotEn = 1'b0; step();
    chk("R3", "pllClosed", pllClosed, 0);
    chk("R4", "rxChainEn", rxChainEn, 1);
    chk("R4", "dcPhase", dcPhase, 1);
    chk("R4", "dcFilt", dcFilt, 1);
    step();
    chk("R4", "dcPhase steady", dcPhase, 1);
    timeLine = 1'b1; step();
    chk("R5", "dcPhase", dcPhase, 2);
    chk("R5", "dcFilt mode0", dcFilt, 2);
    timeLine = 1'b0; step();
    chk("R6", "dcPhase", dcPhase, 3);
    chk("R6", "dcFilt", dcFilt, 3);
    timeLine = 1'b1; step();
    chk("R6", "dcPhase after rise", dcPhase, 3);
    timeLine = 1'b0; step();
    chk("R6", "dcPhase after fall", dcPhase, 3);
    endPulse();
  endtask

  task automatic testRxMode1Hold();
    loadCfg(1'b1, 1'b1, 1'b1, 1'b0);
    slotEn = 1'b1; step();
    slotEn = 1'b0; step();
    chk("R3", "pllClosed held", pllClosed, 1);
    cfgDcMode = 1'b0; cfgPllHold = 1'b0; cfgRx = 1'b0;
    timeLine = 1'b1; step();
    chk("R5", "dcFilt mode1", dcFilt, 3);
    chk("R11", "dcFilt after cfg change", dcFilt, 3);
    chk("R11", "pllClosed after cfg change", pllClosed, 1);
    chk("R11", "ampEn after cfg change", ampEn, 0);
    timeLine = 1'b0; step();
    endPulse();
  endtask

  task automatic testTxRamp0();
    loadCfg(1'b0, 1'b0, 1'b0, 1'b0);
    slotEn = 1'b1; step();
    chk("R2", "preAmpEn", preAmpEn, 1);
    chk("R2", "ampEn", ampEn, 0);
    chk("R2", "txSwitch", txSwitch, 0);
    timeLine = 1'b1; step();
    chk("R7", "ampEn", ampEn, 1);
    chk("R7", "txSwitch before fall", txSwitch, 0);
    chk("R7", "pllClosed still", pllClosed, 1);
    slotEn = 1'b0; step();
    chk("R7", "txSwitch", txSwitch, 1);
    chk("R3", "pllClosed tx", pllClosed, 0);
    timeLine = 1'b0; step();
    chk("R9", "ampEn", ampEn, 1);
    chk("R9", "txSwitch", txSwitch, 1);
    endPulse();
  endtask

  task automatic testTxRamp1();
    loadCfg(1'b0, 1'b0, 1'b0, 1'b1);
    slotEn = 1'b1; step();
    slotEn = 1'b0; step();
    chk("R8", "txSwitch after fall", txSwitch, 0);
    chk("R8", "ampEn after fall", ampEn, 0);
    timeLine = 1'b1; step();
    chk("R8", "ampEn", ampEn, 1);
    chk("R8", "txSwitch", txSwitch, 1);
    timeLine = 1'b0; step();
    chk("R9", "ampEn ramp1", ampEn, 1);
    endPulse();
  endtask

  task automatic testNoCfg();
    cfgRx = 1'b1;
    slotEn = 1'b1; step();
    chkIdle("R10");
    slotEn = 1'b0; step();
    chk("R10", "rxChainEn no cfg", rxChainEn, 0);
    timeLine = 1'b1; step();
    chk("R10", "dcPhase no cfg", dcPhase, 0);
    timeLine = 1'b0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    testReset();
    testRxMode0();
    testRxMode1Hold();
    testTxRamp0();
    testTxRamp1();
    testNoCfg();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule